// File: doc/BRIEF.md
# Stale Data Timeout Timer

This block is a programmable down-counting timer that sits beside a parallel-port data path. It raises a timeout interrupt when data has been idle for too long. Software writes a delay value into the timer. Every data-arrival strobe then restarts the countdown from that value. When the count reaches zero, a stale flag goes high. The rising edge of the stale flag is the timeout trigger.

A direction input decides how the trigger becomes the timeout status:

- **Receive direction:** the status is held back until the data path has drained. Drained means no DMA transfer is in progress, the FIFO is empty and at most one character is left in the pipeline.
- **Transmit direction:** the status is set on the trigger straight away. In this direction the block works as a general-purpose delay timer.

The status stays set until software raises the clear-timeout control. While that control is high, the timeout function is disabled. The interrupt is the status gated by an enable input.

The countdown advances once per prescaler period of `PRESCALE` clocks. A load or an arrival restarts the prescaler, so a loaded value N gives stale exactly N×`PRESCALE` clocks later.

Top module: `stale_timer`

## Requirements
- R1: After reset, `stale`, `to_status` and `irq` are all 0.
- R2: A load with a nonzero value N arms the timer. `stale` rises exactly N×PRESCALE clock edges after the load edge, so a value of 1 expires after PRESCALE edges. A load of 0 disarms the timer, and `stale` then stays 0.
- R3: A `data_arrive` pulse reloads the count from the last loaded value and restarts the prescaler. `stale` drops and expiry is postponed by a full period. A load in the same cycle as an arrival takes priority.
- R4: With `dir_tx`=1, `to_status` becomes 1 one edge after `stale` rises, whatever the drain inputs are.
- R5: With `dir_tx`=0, a trigger is held pending. `to_status` becomes 1 only on an edge where `dma_busy`=0, `fifo_empty`=1 and `pipe_cnt`<=1. `pipe_cnt` is the number of characters in the pipeline, from 0 to 2.
- R6: With `dir_tx`=0, a pending trigger is dropped if `stale` falls before the path drains.
- R7: `to_status` stays 1 until `clr_to` is sampled high. The next edge then clears it. While `clr_to` is 1, no trigger is recorded.
- R8: `irq` is 1 exactly when `to_status`=1 and `irq_en`=1. It is a level, not a pulse.
- R9: Only a 0-to-1 transition of `stale` triggers the timeout. A `stale` level that is still high after a clear does not set `to_status` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write strobe for the timer value |
| load_val | input | CNT_W | Delay value, in prescaler periods |
| data_arrive | input | 1 | Data-arrival strobe; restarts the countdown |
| dir_tx | input | 1 | 1 = transmit behaviour, 0 = receive behaviour |
| dma_busy | input | 1 | A DMA transfer is in progress |
| fifo_empty | input | 1 | The data FIFO holds no characters |
| pipe_cnt | input | PIPE_W | Characters held in the pipeline stages |
| clr_to | input | 1 | Clear-timeout control; disables the timeout while high |
| irq_en | input | 1 | Interrupt enable |
| stale | output | 1 | Count has expired while armed |
| to_status | output | 1 | Timeout status, sticky |
| irq | output | 1 | Level interrupt |

## Verification
The checker runs on every cycle. It checks the following:

- the interrupt gating;
- that the status clears after a clear and holds otherwise;
- that a transmit-direction trigger sets the status on the next edge;
- that a receive-direction status appears only after a drained cycle;
- that the status never rises without the stale flag;
- that a nonzero load drops the stale flag.

Only the bench scenarios can show the following, because they need cycle counts and sequences across many cycles:

- the exact expiry cycle for several loaded values;
- the postponement caused by an arrival;
- the cancelled pending trigger;
- the refusal to re-trigger on a stale level that stays high after a clear.

// File: rtl/stale_timer_pkg.sv
package stale_timer_pkg;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    typedef struct packed {
        logic stale_prev;
        logic pending;
        logic status;
    } status_state_t;

endpackage

// File: rtl/stale_prescaler.sv
module stale_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE > 1) begin : g_div
            localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

            typedef struct packed {
                logic [PRE_W-1:0] phase;
            } pre_state_t;

            pre_state_t pre_d, pre_q;

            always_comb begin
                pre_d = pre_q;
                if (restart) begin
                    pre_d.phase = '0;
                end else if (pre_q.phase == LAST) begin
                    pre_d.phase = '0;
                end else begin
                    pre_d.phase = pre_q.phase + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_d;
                end
            end

            assign tick = (pre_q.phase == LAST) && !restart;
        end else begin : g_pass
            assign tick = !restart;
        end
    endgenerate

endmodule

// File: rtl/stale_counter.sv
module stale_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             data_arrive,
    output logic             stale
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic             armed;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_en) begin
            cnt_d.reload = load_val;
            cnt_d.count  = load_val;
            cnt_d.armed  = (load_val != '0);
        end else if (data_arrive) begin
            cnt_d.count = cnt_q.reload;
        end else if (tick && (cnt_q.count != '0)) begin
            cnt_d.count = cnt_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign stale = cnt_q.armed && (cnt_q.count == '0);

endmodule

// File: rtl/stale_status.sv
module stale_status
    import stale_timer_pkg::*;
#(
    parameter int PIPE_W   = 2,
    parameter int PIPE_MAX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stale,
    input  dir_e              dir,
    input  logic              dma_busy,
    input  logic              fifo_empty,
    input  logic [PIPE_W-1:0] pipe_cnt,
    input  logic              clr_to,
    output logic              status
);
    localparam logic [PIPE_W-1:0] PIPE_LIMIT = PIPE_W'(PIPE_MAX);

    status_state_t st_d, st_q;
    logic          drained;
    logic          rise;
    logic          release_ok;

    always_comb begin
        drained    = !dma_busy && fifo_empty && (pipe_cnt <= PIPE_LIMIT);
        rise       = stale && !st_q.stale_prev;
        release_ok = (dir == DIR_TX) || drained;

        st_d            = st_q;
        st_d.stale_prev = stale;
        if (clr_to) begin
            st_d.status  = 1'b0;
            st_d.pending = 1'b0;
        end else if (stale) begin
            if ((rise || st_q.pending) && release_ok) begin
                st_d.status  = 1'b1;
                st_d.pending = 1'b0;
            end else if (rise) begin
                st_d.pending = 1'b1;
            end
        end else begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.status;

endmodule

// File: rtl/stale_timer.sv
module stale_timer
    import stale_timer_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int PRESCALE = 4,
    parameter int PIPE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              data_arrive,
    input  logic              dir_tx,
    input  logic              dma_busy,
    input  logic              fifo_empty,
    input  logic [PIPE_W-1:0] pipe_cnt,
    input  logic              clr_to,
    input  logic              irq_en,
    output logic              stale,
    output logic              to_status,
    output logic              irq
);
    logic tick;
    logic restart;
    dir_e dir;

    assign restart = load_en || data_arrive;
    assign dir     = dir_tx ? DIR_TX : DIR_RX;

    stale_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    stale_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .load_en     (load_en),
        .load_val    (load_val),
        .data_arrive (data_arrive),
        .stale       (stale)
    );

    stale_status #(.PIPE_W(PIPE_W)) u_st (
        .clk        (clk),
        .rst_n      (rst_n),
        .stale      (stale),
        .dir        (dir),
        .dma_busy   (dma_busy),
        .fifo_empty (fifo_empty),
        .pipe_cnt   (pipe_cnt),
        .clr_to     (clr_to),
        .status     (to_status)
    );

    assign irq = to_status && irq_en;

endmodule

// File: rtl/stale_timer_checker.sv
module stale_timer_checker #(
    parameter int CNT_W  = 8,
    parameter int PIPE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic [CNT_W-1:0]  load_val,
    input logic              dir_tx,
    input logic              dma_busy,
    input logic              fifo_empty,
    input logic [PIPE_W-1:0] pipe_cnt,
    input logic              clr_to,
    input logic              irq_en,
    input logic              stale,
    input logic              to_status,
    input logic              irq
);
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> to_status);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_to |=> !to_status);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (to_status && !clr_to) |=> to_status);

    assert_tx_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_tx && $rose(stale) && !clr_to) |=> to_status);

    assert_rx_drained_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(to_status) && !$past(dir_tx))
            |-> $past(!dma_busy && fifo_empty && (pipe_cnt <= PIPE_W'(1))));

    assert_needs_stale_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_status) |-> $past(stale));

    assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && (load_val != '0)) |=> !stale);

endmodule

bind stale_timer stale_timer_checker #(.CNT_W(CNT_W), .PIPE_W(PIPE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_val   (load_val),
    .dir_tx     (dir_tx),
    .dma_busy   (dma_busy),
    .fifo_empty (fifo_empty),
    .pipe_cnt   (pipe_cnt),
    .clr_to     (clr_to),
    .irq_en     (irq_en),
    .stale      (stale),
    .to_status  (to_status),
    .irq        (irq)
);

// File: tb/stale_timer_bench.sv
module stale_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int P          = 4;
    localparam int PIPE_W     = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_en = 1'b0;
    logic [CNT_W-1:0]  load_val = '0;
    logic              data_arrive = 1'b0;
    logic              dir_tx = 1'b1;
    logic              dma_busy = 1'b0;
    logic              fifo_empty = 1'b1;
    logic [PIPE_W-1:0] pipe_cnt = '0;
    logic              clr_to = 1'b0;
    logic              irq_en = 1'b1;
    logic              stale;
    logic              to_status;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stale_timer #(.CNT_W(CNT_W), .PRESCALE(P), .PIPE_W(PIPE_W)) u_stale_timer (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
        .data_arrive(data_arrive), .dir_tx(dir_tx), .dma_busy(dma_busy),
        .fifo_empty(fifo_empty), .pipe_cnt(pipe_cnt), .clr_to(clr_to),
        .irq_en(irq_en), .stale(stale), .to_status(to_status), .irq(irq)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_load(input logic [CNT_W-1:0] v);
        load_en  = 1'b1;
        load_val = v;
        cyc(1);
        load_en  = 1'b0;
    endtask

    task automatic do_arrive();
        data_arrive = 1'b1;
        cyc(1);
        data_arrive = 1'b0;
    endtask

    task automatic do_clear();
        clr_to = 1'b1;
        cyc(1);
        clr_to = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "stale after reset", stale, 1'b0);
        check("R1", "status after reset", to_status, 1'b0);
        check("R1", "irq after reset", irq, 1'b0);
    endtask

    task automatic t_expiry();
        dir_tx = 1'b1;
        do_load(8'd0);
        do_clear();
        do_load(8'd0);
        cyc(40);
        check("R2", "zero load keeps stale low", stale, 1'b0);
        do_load(8'd1);
        cyc(P - 1);
        check("R2", "value 1 not yet expired", stale, 1'b0);
        cyc(1);
        check("R2", "value 1 expired", stale, 1'b1);
        do_load(8'd5);
        check("R2", "reload drops stale", stale, 1'b0);
        cyc(5 * P - 1);
        check("R2", "value 5 one edge early", stale, 1'b0);
        cyc(1);
        check("R2", "value 5 expired", stale, 1'b1);
    endtask

    task automatic t_tx_immediate();
        dir_tx   = 1'b1;
        dma_busy = 1'b1;
        fifo_empty = 1'b0;
        pipe_cnt = 2'd2;
        do_load(8'd0);
        do_clear();
        do_load(8'd2);
        cyc(2 * P);
        check("R4", "stale risen", stale, 1'b1);
        check("R4", "status not before next edge", to_status, 1'b0);
        cyc(1);
        check("R4", "status set despite busy path", to_status, 1'b1);
        check("R8", "irq with enable", irq, 1'b1);
        dma_busy = 1'b0;
        fifo_empty = 1'b1;
        pipe_cnt = '0;
    endtask

    task automatic t_arrival();
        dir_tx = 1'b1;
        do_load(8'd0);
        do_clear();
        do_load(8'd3);
        cyc(2 * P);
        do_arrive();
        cyc(3 * P - 1);
        check("R3", "arrival postpones expiry", stale, 1'b0);
        check("R3", "no status while postponed", to_status, 1'b0);
        cyc(1);
        check("R3", "expiry after full reload", stale, 1'b1);
        cyc(1);
        check("R3", "status after postponed expiry", to_status, 1'b1);
        do_clear();
        load_en = 1'b1;
        load_val = 8'd2;
        data_arrive = 1'b1;
        cyc(1);
        load_en = 1'b0;
        data_arrive = 1'b0;
        cyc(2 * P - 1);
        check("R3", "load wins over arrival, early", stale, 1'b0);
        cyc(1);
        check("R3", "load wins over arrival, expired", stale, 1'b1);
    endtask

    task automatic t_rx_drain();
        dir_tx = 1'b0;
        dma_busy = 1'b1;
        fifo_empty = 1'b1;
        pipe_cnt = '0;
        do_load(8'd0);
        do_clear();
        do_load(8'd1);
        cyc(P);
        check("R5", "stale in receive", stale, 1'b1);
        cyc(5);
        check("R5", "held while DMA busy", to_status, 1'b0);
        dma_busy = 1'b0;
        fifo_empty = 1'b0;
        cyc(3);
        check("R5", "held while FIFO not empty", to_status, 1'b0);
        fifo_empty = 1'b1;
        pipe_cnt = 2'd2;
        cyc(3);
        check("R5", "held with two pipeline chars", to_status, 1'b0);
        pipe_cnt = 2'd1;
        cyc(1);
        check("R5", "set once drained", to_status, 1'b1);
        pipe_cnt = '0;
    endtask

    task automatic t_rx_cancel();
        dir_tx = 1'b0;
        dma_busy = 1'b1;
        do_load(8'd0);
        do_clear();
        do_load(8'd2);
        cyc(2 * P);
        check("R6", "stale before cancel", stale, 1'b1);
        cyc(2);
        check("R6", "pending while busy", to_status, 1'b0);
        data_arrive = 1'b1;
        cyc(1);
        data_arrive = 1'b0;
        dma_busy = 1'b0;
        check("R6", "arrival drops stale", stale, 1'b0);
        cyc(2);
        check("R6", "pending dropped after stale fell", to_status, 1'b0);
        cyc(2 * P - 3);
        check("R6", "no status before new expiry", to_status, 1'b0);
        cyc(1);
        check("R6", "new expiry", stale, 1'b1);
        cyc(1);
        check("R6", "status from new expiry", to_status, 1'b1);
    endtask

    task automatic t_clear_edge();
        dir_tx = 1'b1;
        do_load(8'd0);
        do_clear();
        do_load(8'd1);
        cyc(P + 1);
        check("R7", "status set", to_status, 1'b1);
        cyc(3);
        check("R7", "status sticky", to_status, 1'b1);
        clr_to = 1'b1;
        cyc(1);
        check("R7", "status cleared", to_status, 1'b0);
        check("R7", "irq cleared", irq, 1'b0);
        do_load(8'd1);
        cyc(P + 2);
        check("R7", "trigger ignored while clear held", to_status, 1'b0);
        clr_to = 1'b0;
        cyc(3);
        check("R9", "stale level still high", stale, 1'b1);
        check("R9", "no retrigger on level", to_status, 1'b0);
        do_arrive();
        cyc(P - 1);
        check("R9", "stale low after arrival", stale, 1'b0);
        cyc(1);
        cyc(1);
        check("R9", "new rising edge triggers", to_status, 1'b1);
    endtask

    task automatic t_irq();
        dir_tx = 1'b1;
        irq_en = 1'b0;
        do_load(8'd0);
        do_clear();
        do_load(8'd1);
        cyc(P + 1);
        check("R8", "status set with irq disabled", to_status, 1'b1);
        check("R8", "irq masked", irq, 1'b0);
        irq_en = 1'b1;
        #1;
        check("R8", "irq follows enable", irq, 1'b1);
        cyc(4);
        check("R8", "irq stays as level", irq, 1'b1);
        irq_en = 1'b0;
        #1;
        check("R8", "irq masked again", irq, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_expiry();
        t_tx_immediate();
        t_arrival();
        t_rx_drain();
        t_rx_cancel();
        t_clear_edge();
        t_irq();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule